// File: doc/BRIEF.md
# Byte-Wide Load/Store Instruction Sequencer

This block is the machine-cycle sequencer for the data-transfer subset of an 8-bit accumulator processor. It fetches an opcode and any operand bytes from a byte-wide synchronous memory port. It then performs the memory read or write cycles that the instruction needs and updates its register file. The register file holds the accumulator, the six general byte registers, which pair up as BC, DE and HL, and a 16-bit stack pointer. Six instruction forms are handled:
- loading a 16-bit constant into a register pair;
- moving the accumulator to or from a directly addressed byte;
- moving the HL pair to or from two consecutive directly addressed bytes;
- loading the accumulator through the address held in BC or DE.

Each memory cycle is one request that is held until the memory answers with a one-cycle ready. After the final cycle of every instruction the sequencer pulses `done`. Two totals are valid with that pulse: the number of machine cycles the instruction used and the number of clock states it used. An opcode fetch counts as 4 states and every other memory cycle counts as 3, so a bench can check the timing totals without bus timing signals. Any opcode outside the handled set stops the sequencer and raises a sticky illegal flag.

Top module: `ldst_seq`

## Requirements
- R1: After reset the PC, all byte registers and SP are zero, `done` and `illegal` are low, and the first request is a read (`mem_we`=0) of address 0.
- R2: Opcode `00pp0001` loads a 16-bit immediate into a pair: pp=00 BC, 01 DE, 10 HL, 11 SP. Byte 2 goes to the low register and byte 3 to the high register. It takes 3 machine cycles and 10 states.
- R3: Opcode 0x3A loads A from address {byte3, byte2}, with byte 2 as the low half. It takes 4 cycles and 13 states.
- R4: Opcode 0x32 writes A to address {byte3, byte2}. It takes 4 cycles and 13 states.
- R5: Opcode 0x2A loads L from address N and H from N+1, with N+1 taken modulo 65536. It takes 5 cycles and 16 states.
- R6: Opcode 0x22 writes L to address N and H to N+1, with N+1 taken modulo 65536. It takes 5 cycles and 16 states.
- R7: Opcodes 0x0A and 0x1A load A from the address held in BC or DE respectively. They take 2 cycles and 7 states.
- R8: The PC advances by one for each fetched instruction byte and changes at no other time.
- R9: Each machine cycle is exactly one request. Address, direction and write data are held steady until `mem_rdy` is seen.
- R10: `done` is a single-cycle pulse after the last cycle of an instruction. With it, `cyc_total` and `state_total` equal the instruction's totals, where states = 4 + 3 × (cycles − 1).
- R11: An unsupported opcode raises `illegal`, which stays high until reset. From then on no requests are issued and no register changes.
- R12: An instruction changes no register other than those named in its requirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Memory completes the current cycle |
| done | output | 1 | Instruction completed (one cycle) |
| illegal | output | 1 | Sticky unsupported-opcode flag |
| cyc_total | output | 3 | Machine cycles of the last instruction |
| state_total | output | 5 | States of the last instruction |
| pc | output | 16 | Program counter |
| reg_a | output | 8 | Accumulator |
| reg_b | output | 8 | Register B |
| reg_c | output | 8 | Register C |
| reg_d | output | 8 | Register D |
| reg_e | output | 8 | Register E |
| reg_h | output | 8 | Register H |
| reg_l | output | 8 | Register L |
| sp | output | 16 | Stack pointer |

## Verification
A directed prologue loads every pair and then aims accumulator and HL transfers at address 0xFFFF. This separates a correct modulo-65536 second address from one that carries into a 17th bit, and it separates byte-order swaps in immediate and direct addressing. A random mix of all six forms then follows, with random pairs, operands and data addresses and random memory wait states. The wait states show whether request fields stay steady and whether the cycle and state totals count handshakes rather than clocks. Checking every register after every instruction catches writes to the wrong half or the wrong pair. A final unsupported opcode tests the halt.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   localparam int NUM_BREG  = 7;
   localparam int MAX_MCYC  = 5;

   typedef enum logic [2:0] {
      PH_FETCH,
      PH_OPLO,
      PH_OPHI,
      PH_XFER1,
      PH_XFER2,
      PH_HALT
   } phase_t;

   typedef enum logic [2:0] {
      OC_IMM16,
      OC_LDACC,
      OC_STACC,
      OC_LDPAIR,
      OC_STPAIR,
      OC_LDIND,
      OC_BAD
   } opclass_t;

   typedef enum logic [2:0] {
      BR_A,
      BR_B,
      BR_C,
      BR_D,
      BR_E,
      BR_H,
      BR_L
   } breg_t;

   typedef struct packed {
      opclass_t   cls;
      logic [1:0] rp;
   } decoded_t;

   // Pair index that a byte register belongs to (0=BC,1=DE,2=HL).
   function automatic logic [1:0] pair_of_reg(input int idx);
      case (idx)
         1, 2:    return 2'd0;
         3, 4:    return 2'd1;
         5, 6:    return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

   // True when a byte register is the upper half of its pair.
   function automatic bit reg_is_high(input int idx);
      return (idx == 1) || (idx == 3) || (idx == 5);
   endfunction

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
   import ldst_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opcode,
   output decoded_t          dec
);

   localparam logic [7:0] OPC_LDACC  = 8'h3A;
   localparam logic [7:0] OPC_STACC  = 8'h32;
   localparam logic [7:0] OPC_LDPAIR = 8'h2A;
   localparam logic [7:0] OPC_STPAIR = 8'h22;
   localparam logic [7:0] OPC_LDIBC  = 8'h0A;
   localparam logic [7:0] OPC_LDIDE  = 8'h1A;

   always_comb begin
      dec.rp = opcode[5:4];
      if (opcode[7:6] == 2'b00 && opcode[3:0] == 4'b0001) begin
         dec.cls = OC_IMM16;
      end else begin
         case (opcode)
            OPC_LDACC:              dec.cls = OC_LDACC;
            OPC_STACC:              dec.cls = OC_STACC;
            OPC_LDPAIR:             dec.cls = OC_LDPAIR;
            OPC_STPAIR:             dec.cls = OC_STPAIR;
            OPC_LDIBC, OPC_LDIDE:   dec.cls = OC_LDIND;
            default:                dec.cls = OC_BAD;
         endcase
      end
   end

endmodule

// File: rtl/ldst_regfile.sv
module ldst_regfile
   import ldst_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               byte_we,
   input  breg_t                              byte_sel,
   input  logic [DATA_W-1:0]                  byte_din,
   input  logic                               pair_we,
   input  logic [1:0]                         pair_sel,
   input  logic [2*DATA_W-1:0]                pair_din,
   output logic [NUM_BREG-1:0][DATA_W-1:0]    regs_q,
   output logic [2*DATA_W-1:0]                sp_q
);

   localparam logic [1:0] SP_PAIR = 2'd3;

   for (genvar g = 0; g < NUM_BREG; g++) begin : g_breg
      localparam bit         HAS_PAIR = (g != int'(BR_A));
      localparam logic [1:0] PIDX     = pair_of_reg(g);
      localparam bit         IS_HI    = reg_is_high(g);

      logic [DATA_W-1:0] q_r;
      logic              pair_hit;

      assign pair_hit = HAS_PAIR && pair_we && (pair_sel == PIDX);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_r <= '0;
         end else if (byte_we && byte_sel == breg_t'(g)) begin
            q_r <= byte_din;
         end else if (pair_hit) begin
            q_r <= IS_HI ? pair_din[2*DATA_W-1:DATA_W] : pair_din[DATA_W-1:0];
         end
      end

      assign regs_q[g] = q_r;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else if (pair_we && pair_sel == SP_PAIR) begin
         sp_q <= pair_din;
      end
   end

endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
   import ldst_pkg::*;
#(
   parameter int          DATA_W       = 8,
   parameter int          ADDR_W       = 16,
   parameter logic [15:0] RESET_PC     = 16'h0000,
   parameter int          FETCH_STATES = 4,
   parameter int          MEM_STATES   = 3,
   parameter int          CYC_W        = 3,
   parameter int          ST_W         = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             mem_rdy,
   input  logic [DATA_W-1:0]                mem_rdata,
   input  decoded_t                         dec,
   input  logic [NUM_BREG-1:0][DATA_W-1:0]  regs,
   output logic                             mem_req,
   output logic                             mem_we,
   output logic [ADDR_W-1:0]                mem_addr,
   output logic [DATA_W-1:0]                mem_wdata,
   output logic                             byte_we,
   output breg_t                            byte_sel,
   output logic [DATA_W-1:0]                byte_din,
   output logic                             pair_we,
   output logic [1:0]                       pair_sel,
   output logic [2*DATA_W-1:0]              pair_din,
   output logic [ADDR_W-1:0]                pc,
   output logic                             done,
   output logic                             illegal,
   output logic [CYC_W-1:0]                 cyc_total,
   output logic [ST_W-1:0]                  st_total
);

   phase_t            phase_q, phase_d;
   opclass_t          cls_q;
   logic [1:0]        rp_q;
   logic [DATA_W-1:0] lo_q;
   logic [ADDR_W-1:0] pc_q, ea_q, ind_addr;
   logic [CYC_W-1:0]  cyc_q, cyc_next;
   logic [ST_W-1:0]   st_q, st_next;
   logic              hs, last_cyc;

   assign hs = mem_req && mem_rdy;

   // Address held by the pair an indirect load names (bit 0 of rp picks DE).
   assign ind_addr = dec.rp[0] ? {regs[BR_D], regs[BR_E]} : {regs[BR_B], regs[BR_C]};

   // Per-cycle totals, counted in handshakes rather than clocks.
   always_comb begin
      if (phase_q == PH_FETCH) begin
         cyc_next = CYC_W'(1);
         st_next  = ST_W'(FETCH_STATES);
      end else begin
         cyc_next = cyc_q + CYC_W'(1);
         st_next  = st_q + ST_W'(MEM_STATES);
      end
   end

   // Memory port and completion of the current machine cycle.
   always_comb begin
      mem_req   = (phase_q != PH_HALT);
      mem_we    = 1'b0;
      mem_addr  = pc_q;
      mem_wdata = regs[BR_L];
      last_cyc  = 1'b0;
      unique case (phase_q)
         PH_OPHI:  last_cyc = (cls_q == OC_IMM16);
         PH_XFER1: begin
            mem_addr  = ea_q;
            mem_we    = (cls_q == OC_STACC) || (cls_q == OC_STPAIR);
            mem_wdata = (cls_q == OC_STACC) ? regs[BR_A] : regs[BR_L];
            last_cyc  = (cls_q != OC_LDPAIR) && (cls_q != OC_STPAIR);
         end
         PH_XFER2: begin
            mem_addr  = ea_q + ADDR_W'(1);
            mem_we    = (cls_q == OC_STPAIR);
            mem_wdata = regs[BR_H];
            last_cyc  = 1'b1;
         end
         default: ;
      endcase
   end

   // Next phase after a handshake.
   always_comb begin
      phase_d = phase_q;
      if (hs) begin
         unique case (phase_q)
            PH_FETCH: begin
               if (dec.cls == OC_BAD)        phase_d = PH_HALT;
               else if (dec.cls == OC_LDIND) phase_d = PH_XFER1;
               else                          phase_d = PH_OPLO;
            end
            PH_OPLO:  phase_d = PH_OPHI;
            PH_OPHI:  phase_d = (cls_q == OC_IMM16) ? PH_FETCH : PH_XFER1;
            PH_XFER1: phase_d = last_cyc ? PH_FETCH : PH_XFER2;
            PH_XFER2: phase_d = PH_FETCH;
            default:  phase_d = phase_q;
         endcase
      end
   end

   // Register file write requests, applied on the completing handshake.
   always_comb begin
      byte_we  = 1'b0;
      byte_sel = BR_A;
      byte_din = mem_rdata;
      pair_we  = 1'b0;
      pair_sel = rp_q;
      pair_din = {mem_rdata, lo_q};
      if (hs) begin
         unique case (phase_q)
            PH_OPHI:  pair_we = (cls_q == OC_IMM16);
            PH_XFER1: begin
               byte_we  = (cls_q == OC_LDACC) || (cls_q == OC_LDIND) || (cls_q == OC_LDPAIR);
               byte_sel = (cls_q == OC_LDPAIR) ? BR_L : BR_A;
            end
            PH_XFER2: begin
               byte_we  = (cls_q == OC_LDPAIR);
               byte_sel = BR_H;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_FETCH;
         cls_q     <= OC_BAD;
         rp_q      <= '0;
         lo_q      <= '0;
         pc_q      <= ADDR_W'(RESET_PC);
         ea_q      <= '0;
         cyc_q     <= '0;
         st_q      <= '0;
         cyc_total <= '0;
         st_total  <= '0;
         done      <= 1'b0;
         illegal   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done    <= hs && last_cyc;
         if (hs) begin
            cyc_q <= cyc_next;
            st_q  <= st_next;
            if (last_cyc) begin
               cyc_total <= cyc_next;
               st_total  <= st_next;
            end
            if (phase_q == PH_FETCH || phase_q == PH_OPLO || phase_q == PH_OPHI) begin
               pc_q <= pc_q + ADDR_W'(1);
            end
            if (phase_q == PH_FETCH) begin
               cls_q   <= dec.cls;
               rp_q    <= dec.rp;
               illegal <= (dec.cls == OC_BAD);
               ea_q    <= ind_addr;
            end
            if (phase_q == PH_OPLO) begin
               lo_q <= mem_rdata;
            end
            if (phase_q == PH_OPHI) begin
               ea_q <= {mem_rdata, lo_q};
            end
         end
      end
   end

   assign pc = pc_q;

endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
   import ldst_pkg::*;
#(
   parameter int          DATA_W       = 8,
   parameter int          ADDR_W       = 16,
   parameter logic [15:0] RESET_PC     = 16'h0000,
   parameter int          FETCH_STATES = 4,
   parameter int          MEM_STATES   = 3,
   parameter int          CYC_W        = $clog2(MAX_MCYC + 1),
   parameter int          ST_W         = $clog2(FETCH_STATES + (MAX_MCYC - 1) * MEM_STATES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rdy,
   output logic              done,
   output logic              illegal,
   output logic [CYC_W-1:0]  cyc_total,
   output logic [ST_W-1:0]   state_total,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] reg_a,
   output logic [DATA_W-1:0] reg_b,
   output logic [DATA_W-1:0] reg_c,
   output logic [DATA_W-1:0] reg_d,
   output logic [DATA_W-1:0] reg_e,
   output logic [DATA_W-1:0] reg_h,
   output logic [DATA_W-1:0] reg_l,
   output logic [ADDR_W-1:0] sp
);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("ldst_seq: opcode decode needs DATA_W of 8");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr_w
      $error("ldst_seq: ADDR_W must equal two operand bytes");
   end
   if (FETCH_STATES < 1 || MEM_STATES < 1) begin : g_bad_states
      $error("ldst_seq: state weights must be positive");
   end

   decoded_t                          dec;
   logic [NUM_BREG-1:0][DATA_W-1:0]   regs;
   logic                              byte_we, pair_we;
   breg_t                             byte_sel;
   logic [DATA_W-1:0]                 byte_din;
   logic [1:0]                        pair_sel;
   logic [2*DATA_W-1:0]               pair_din;

   ldst_decode #(.DATA_W(DATA_W)) i_decode (
      .opcode (mem_rdata),
      .dec    (dec)
   );

   ldst_ctrl #(
      .DATA_W       (DATA_W),
      .ADDR_W       (ADDR_W),
      .RESET_PC     (RESET_PC),
      .FETCH_STATES (FETCH_STATES),
      .MEM_STATES   (MEM_STATES),
      .CYC_W        (CYC_W),
      .ST_W         (ST_W)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_rdy   (mem_rdy),
      .mem_rdata (mem_rdata),
      .dec       (dec),
      .regs      (regs),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .byte_we   (byte_we),
      .byte_sel  (byte_sel),
      .byte_din  (byte_din),
      .pair_we   (pair_we),
      .pair_sel  (pair_sel),
      .pair_din  (pair_din),
      .pc        (pc),
      .done      (done),
      .illegal   (illegal),
      .cyc_total (cyc_total),
      .st_total  (state_total)
   );

   ldst_regfile #(.DATA_W(DATA_W)) i_regfile (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_we  (byte_we),
      .byte_sel (byte_sel),
      .byte_din (byte_din),
      .pair_we  (pair_we),
      .pair_sel (pair_sel),
      .pair_din (pair_din),
      .regs_q   (regs),
      .sp_q     (sp)
   );

   assign reg_a = regs[BR_A];
   assign reg_b = regs[BR_B];
   assign reg_c = regs[BR_C];
   assign reg_d = regs[BR_D];
   assign reg_e = regs[BR_E];
   assign reg_h = regs[BR_H];
   assign reg_l = regs[BR_L];

endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk #(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 16,
   parameter int FETCH_STATES = 4,
   parameter int MEM_STATES   = 3,
   parameter int CYC_W        = 3,
   parameter int ST_W         = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_rdy,
   input logic              done,
   input logic              illegal,
   input logic [CYC_W-1:0]  cyc_total,
   input logic [ST_W-1:0]   state_total,
   input logic [ADDR_W-1:0] pc
);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R9
   we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   state_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(state_total) == FETCH_STATES + (int'(cyc_total) - 1) * MEM_STATES));

   // R10
   cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc_total >= CYC_W'(2) && cyc_total <= CYC_W'(5)));

   // R11
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> (illegal && !mem_req && !done));

   // R8
   pc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && mem_rdy) |=> $stable(pc));

endmodule

bind ldst_seq ldst_seq_chk #(
   .DATA_W       (DATA_W),
   .ADDR_W       (ADDR_W),
   .FETCH_STATES (FETCH_STATES),
   .MEM_STATES   (MEM_STATES),
   .CYC_W        (CYC_W),
   .ST_W         (ST_W)
) i_ldst_seq_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_rdy     (mem_rdy),
   .done        (done),
   .illegal     (illegal),
   .cyc_total   (cyc_total),
   .state_total (state_total),
   .pc          (pc)
);

// File: tb/test_ldst_seq.sv
module test_ldst_seq;

   localparam int N_RAND = 150;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req, mem_we, mem_rdy = 1'b0;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata = 8'h00;
   logic        done, illegal;
   logic [2:0]  cyc_total;
   logic [4:0]  state_total;
   logic [15:0] pc, sp;
   logic [7:0]  reg_a, reg_b, reg_c, reg_d, reg_e, reg_h, reg_l;

   ldst_seq i_ldst_seq (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_rdy(mem_rdy), .done(done), .illegal(illegal), .cyc_total(cyc_total),
      .state_total(state_total), .pc(pc), .reg_a(reg_a), .reg_b(reg_b),
      .reg_c(reg_c), .reg_d(reg_d), .reg_e(reg_e), .reg_h(reg_h),
      .reg_l(reg_l), .sp(sp)
   );

   always #2 clk = ~clk;

   logic [7:0] mem [logic [15:0]];
   int checks = 0, errors = 0;
   int hs_count = 0, hs_snap = 0;
   int n_instr = 0;
   logic [15:0] gen_pc = 16'h0000;

   function automatic logic [7:0] rd(input logic [15:0] a);
      if (mem.exists(a)) return mem[a];
      return 8'h00;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic emit(input logic [7:0] b);
      mem[gen_pc] = b;
      gen_pc = gen_pc + 16'd1;
   endtask

   task automatic emit3(input logic [7:0] op, input logic [15:0] v);
      emit(op); emit(v[7:0]); emit(v[15:8]);
      n_instr++;
   endtask

   task automatic emit1(input logic [7:0] op);
      emit(op);
      n_instr++;
   endtask

   function automatic logic [15:0] rand_data_addr();
      if ($urandom % 8 == 0) return 16'hFFFF;
      return 16'h8000 | 16'($urandom % 256);
   endfunction

   // Memory responder: random waits, one handshake counted per ready.
   logic gave = 1'b0;
   initial begin
      forever begin
         @(negedge clk);
         if (gave) hs_count++;
         if (done) begin
            hs_snap  = hs_count;
            hs_count = 0;
         end
         gave = 1'b0;
         if (rst_n && mem_req && ($urandom % 3 != 0)) begin
            mem_rdy = 1'b1;
            gave    = 1'b1;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        mem_rdata = rd(mem_addr);
         end else begin
            mem_rdy = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // Expected-state model.
   logic [7:0]  ea, eb, ec, ed, ee, eh, el;
   logic [15:0] esp, epc;

   task automatic check_regs(input string tag);
      chk({tag, " A"}, 32'(reg_a), 32'(ea));
      chk({tag, " B"}, 32'(reg_b), 32'(eb));
      chk({tag, " C"}, 32'(reg_c), 32'(ec));
      chk({tag, " D"}, 32'(reg_d), 32'(ed));
      chk({tag, " E"}, 32'(reg_e), 32'(ee));
      chk({tag, " H"}, 32'(reg_h), 32'(eh));
      chk({tag, " L"}, 32'(reg_l), 32'(el));
      chk({tag, " SP"}, 32'(sp), 32'(esp));
   endtask

   task automatic wait_done(output bit ok);
      int waited = 0;
      ok = 1'b0;
      while (waited < 200) begin
         @(negedge clk); #1;
         waited++;
         if (done) begin ok = 1'b1; break; end
      end
   endtask

   task automatic run_one();
      logic [7:0]  op, b2, b3;
      logic [15:0] nn, ptr;
      int          len, ecyc, est;
      string       tag;
      bit          ok;
      op = rd(epc); b2 = rd(epc + 16'd1); b3 = rd(epc + 16'd2);
      nn = {b3, b2};
      wait_done(ok);
      if (!ok) begin
         errors++;
         $display("FAIL R10: actual no done expected done for opcode %0h", op);
         return;
      end
      if (op[7:6] == 2'b00 && op[3:0] == 4'b0001) begin
         tag = "R2"; len = 3; ecyc = 3; est = 10;
         case (op[5:4])
            2'b00: begin eb = b3; ec = b2; end
            2'b01: begin ed = b3; ee = b2; end
            2'b10: begin eh = b3; el = b2; end
            default: esp = nn;
         endcase
      end else begin
         case (op)
            8'h3A: begin tag = "R3"; len = 3; ecyc = 4; est = 13; ea = rd(nn); end
            8'h32: begin
               tag = "R4"; len = 3; ecyc = 4; est = 13;
               chk("R4 stored byte", 32'(rd(nn)), 32'(ea));
            end
            8'h2A: begin
               tag = "R5"; len = 3; ecyc = 5; est = 16;
               el = rd(nn); eh = rd(nn + 16'd1);
            end
            8'h22: begin
               tag = "R6"; len = 3; ecyc = 5; est = 16;
               chk("R6 stored L", 32'(rd(nn)), 32'(el));
               chk("R6 stored H at N+1", 32'(rd(nn + 16'd1)), 32'(eh));
            end
            default: begin
               tag = "R7"; len = 1; ecyc = 2; est = 7;
               ptr = (op == 8'h1A) ? {ed, ee} : {eb, ec};
               ea = rd(ptr);
            end
         endcase
      end
      epc = epc + 16'(len);
      check_regs({tag, "/R12"});
      chk({tag, "/R8 pc"}, 32'(pc), 32'(epc));
      chk({tag, "/R10 cycles"}, 32'(cyc_total), 32'(ecyc));
      chk({tag, "/R10 states"}, 32'(state_total), 32'(est));
      chk({tag, "/R9 handshakes"}, 32'(hs_snap), 32'(ecyc));
   endtask

   initial begin
      logic [15:0] ill_pc;
      bit          seen;
      void'($urandom(32'h1A2B3C4D));
      for (int i = 0; i < 256; i++) mem[16'h8000 + 16'(i)] = 8'($urandom);
      mem[16'hFFFF] = 8'h5C;
      // Directed prologue.
      emit3(8'h01, 16'h8010);     // pair BC
      emit3(8'h11, 16'h8020);     // pair DE
      emit3(8'h21, 16'h1234);     // pair HL
      emit3(8'h31, 16'hBEEF);     // SP
      emit1(8'h0A);               // indirect via BC
      emit1(8'h1A);               // indirect via DE
      emit3(8'h3A, 16'hFFFF);     // load A, top address
      emit3(8'h2A, 16'hFFFF);     // pair load wrapping to 0
      emit3(8'h21, 16'hA55A);
      emit3(8'h22, 16'hFFFF);     // pair store wrapping to 0
      emit3(8'h32, 16'h80FF);
      for (int i = 0; i < N_RAND; i++) begin
         case ($urandom % 6)
            0: emit3({2'b00, 2'($urandom), 4'b0001}, 16'($urandom));
            1: emit3(8'h3A, rand_data_addr());
            2: emit3(8'h32, rand_data_addr());
            3: emit3(8'h2A, rand_data_addr());
            4: emit3(8'h22, rand_data_addr());
            default: emit1(($urandom % 2 == 0) ? 8'h0A : 8'h1A);
         endcase
      end
      ill_pc = gen_pc;
      mem[gen_pc] = 8'h76;        // not a handled opcode

      ea = 0; eb = 0; ec = 0; ed = 0; ee = 0; eh = 0; el = 0; esp = 0; epc = 0;
      repeat (3) @(negedge clk);
      #1;
      check_regs("R1 reset");
      chk("R1 pc", 32'(pc), 32'h0);
      chk("R1 done", 32'(done), 32'h0);
      chk("R1 illegal", 32'(illegal), 32'h0);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 first request", 32'({mem_req, mem_we, mem_addr}), 32'({1'b1, 1'b0, 16'h0000}));

      for (int i = 0; i < n_instr; i++) run_one();

      seen = 1'b0;
      for (int i = 0; i < 40 && !seen; i++) begin
         @(negedge clk); #1;
         seen = illegal;
      end
      chk("R11 illegal raised", 32'(illegal), 32'h1);
      repeat (10) begin
         @(negedge clk); #1;
         chk("R11 no request", 32'(mem_req), 32'h0);
         chk("R11 no done", 32'(done), 32'h0);
      end
      check_regs("R11 frozen");
      chk("R11 pc", 32'(pc), 32'(ill_pc + 16'd1));
      chk("R11 still illegal", 32'(illegal), 32'h1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule